// File: doc/BRIEF.md
# Interrupt Status Aggregator for an Audio Controller

This block gathers every interrupt source of an audio controller into one 32-bit status word and one level-sensitive interrupt line. It watches the response-ring status and control bytes, the codec state-change flags and their wake-enable mask, and one status byte and one control byte for each stream descriptor. The block only observes these registers. Decoding the register bus and clearing status bits on a write of one happen elsewhere.

Stream descriptors are numbered with the capture (input) streams first and the playback (output) streams after them. Stream `n` reports on bit `n` of the status word. Bit 30 holds the controller summary and bit 31 holds the global summary. The status word is combinational, so it always reflects the current source registers. The interrupt line is a register. It follows the status word ANDed with the interrupt-control word one clock later, and it changes only when its level must differ from the level it has now.

The global summary bit can be set while every enable is off. That bit only reports; the line is gated on its own by the global enable, the controller enable and the per-stream enables.

Top module: `hda_irq_agg`

## Requirements
- R1: Status bit 30 is set when `ring_sts & ring_ctl` has bit 0 (response interrupt) or bit 2 (overrun interrupt) set. All other ring bits have no effect on the status word.
- R2: Status bit 30 is set whenever any bit of `codec_chg` is set, including when `codec_chg & wake_en` is nonzero. `wake_en` never clears a flag that `codec_chg` already reports.
- R3: For stream `n` (capture streams at indices 0 to NUM_IN-1, playback streams above them), status bit `n` is set when `sd_sts` byte `n` ANDed with `sd_ctl` byte `n` has bit 2 (completion), bit 3 (FIFO error) or bit 4 (descriptor error) set. Other bits of those bytes are ignored.
- R4: Status bit 31 is the OR of bit 30 and all stream bits. Bits NUM_IN+NUM_OUT through 29 always read as zero. The status word changes combinationally, with no clock delay.
- R5: One clock edge after the inputs settle, `irq_line` is high exactly when `intr_ctl[31]` is set and either (status bit 30 AND `intr_ctl[30]`) or some (stream bit `n` AND `intr_ctl[n]`) holds.
- R6: When status bit 31 is set but the enables do not qualify any source, `irq_line` stays low.
- R7: While `rst_n` is low, `irq_line` is low.
- R8: `irq_line` changes only on a clock edge at which the required level differs from the current level. It never changes between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_sts | input | 8 | Response-ring status byte |
| ring_ctl | input | 8 | Response-ring control byte |
| codec_chg | input | CODEC_W | Codec state-change flags |
| wake_en | input | CODEC_W | Wake-enable mask for the codec flags |
| sd_sts | input | 8*(NUM_IN+NUM_OUT) | Stream status bytes, byte `n` for stream `n` |
| sd_ctl | input | 8*(NUM_IN+NUM_OUT) | Stream control bytes, byte `n` for stream `n` |
| intr_ctl | input | 32 | Interrupt control: bit 31 global enable, bit 30 controller enable, bit `n` stream enable |
| int_sts | output | 32 | Computed interrupt status word |
| irq_line | output | 1 | Registered level interrupt line |

## Verification
The bench builds the block with two capture and two playback streams. With that small configuration, every pair of status and control bytes for a stream can be swept, and so can every pair of response-ring bytes. The line sweep covers every combination of the four stream sources, the controller source and the six relevant enable bits. This reaches each case where the summary bit is set while the line must stay low. It also reaches each assert and deassert transition, which the bench samples both before and after the edge.

// File: rtl/hda_irq_pkg.sv
package hda_irq_pkg;
  localparam int STS_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int CTRL_POS  = 30;
  localparam int GLOB_POS  = 31;
  // Response-ring bits that raise the controller source.
  localparam int RING_RESP = 0;
  localparam int RING_OVR  = 2;
  // Stream status/control bits that raise a stream source.
  localparam int SD_DONE   = 2;
  localparam int SD_FIFO   = 3;
  localparam int SD_DESC   = 4;

  localparam logic [BYTE_W-1:0] RING_MASK =
    BYTE_W'((1 << RING_RESP) | (1 << RING_OVR));
  localparam logic [BYTE_W-1:0] SD_MASK =
    BYTE_W'((1 << SD_DONE) | (1 << SD_FIFO) | (1 << SD_DESC));

  function automatic logic ring_hit(input logic [BYTE_W-1:0] s,
                                    input logic [BYTE_W-1:0] c);
    return |(s & c & RING_MASK);
  endfunction

  function automatic logic sd_hit(input logic [BYTE_W-1:0] s,
                                  input logic [BYTE_W-1:0] c);
    return |(s & c & SD_MASK);
  endfunction

  function automatic logic line_want(input logic [STS_W-1:0] sts,
                                     input logic [STS_W-1:0] ctl);
    return ctl[GLOB_POS] & (|(sts[GLOB_POS-1:0] & ctl[GLOB_POS-1:0]));
  endfunction
endpackage

// File: rtl/hda_irq_ctrl_src.sv
module hda_irq_ctrl_src
  import hda_irq_pkg::*;
#(
  parameter int CODEC_W = 15
) (
  input  logic [BYTE_W-1:0]  ring_sts,
  input  logic [BYTE_W-1:0]  ring_ctl,
  input  logic [CODEC_W-1:0] codec_chg,
  input  logic [CODEC_W-1:0] wake_en,
  output logic               ctrl_hit
);
  logic ring_src;
  logic chg_src;
  logic wake_src;

  always_comb begin
    ring_src = ring_hit(ring_sts, ring_ctl);
    chg_src  = |codec_chg;
    wake_src = |(codec_chg & wake_en);
    ctrl_hit = ring_src | chg_src | wake_src;
  end
endmodule

// File: rtl/hda_irq_strm_src.sv
module hda_irq_strm_src
  import hda_irq_pkg::*;
#(
  parameter int NS = 8
) (
  input  logic [NS*BYTE_W-1:0] sd_sts,
  input  logic [NS*BYTE_W-1:0] sd_ctl,
  output logic [NS-1:0]        strm_hit
);
  for (genvar n = 0; n < NS; n++) begin : g_sd
    assign strm_hit[n] = sd_hit(sd_sts[n*BYTE_W +: BYTE_W],
                                sd_ctl[n*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/hda_irq_line.sv
module hda_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic irq,
  output logic up_evt,
  output logic dn_evt
);
  logic irq_q;

  assign up_evt = want & ~irq_q;
  assign dn_evt = ~want & irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (up_evt) irq_q <= 1'b1;
    else if (dn_evt) irq_q <= 1'b0;
  end

  assign irq = irq_q;
endmodule

// File: rtl/hda_irq_agg.sv
module hda_irq_agg
  import hda_irq_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int CODEC_W = 15
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [7:0]                       ring_sts,
  input  logic [7:0]                       ring_ctl,
  input  logic [CODEC_W-1:0]               codec_chg,
  input  logic [CODEC_W-1:0]               wake_en,
  input  logic [(NUM_IN+NUM_OUT)*8-1:0]    sd_sts,
  input  logic [(NUM_IN+NUM_OUT)*8-1:0]    sd_ctl,
  input  logic [31:0]                      intr_ctl,
  output logic [31:0]                      int_sts,
  output logic                             irq_line
);
  localparam int NS = NUM_IN + NUM_OUT;

  logic          ctrl_hit;
  logic [NS-1:0] strm_hit;
  logic [31:0]   sts_w;
  logic          want;
  logic          line_up;
  logic          line_dn;

  hda_irq_ctrl_src #(.CODEC_W(CODEC_W)) u_ctrl (
    .ring_sts (ring_sts),
    .ring_ctl (ring_ctl),
    .codec_chg(codec_chg),
    .wake_en  (wake_en),
    .ctrl_hit (ctrl_hit)
  );

  hda_irq_strm_src #(.NS(NS)) u_strm (
    .sd_sts  (sd_sts),
    .sd_ctl  (sd_ctl),
    .strm_hit(strm_hit)
  );

  always_comb begin
    sts_w           = '0;
    sts_w[NS-1:0]   = strm_hit;
    sts_w[CTRL_POS] = ctrl_hit;
    sts_w[GLOB_POS] = ctrl_hit | (|strm_hit);
    want            = line_want(sts_w, intr_ctl);
  end

  hda_irq_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (want),
    .irq   (irq_line),
    .up_evt(line_up),
    .dn_evt(line_dn)
  );

  assign int_sts = sts_w;
endmodule

// File: rtl/hda_irq_agg_chk.sv
module hda_irq_agg_chk #(
  parameter int NS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] int_sts,
  input logic [31:0] intr_ctl,
  input logic        irq_line,
  input logic        line_up,
  input logic        line_dn
);
  localparam logic [31:0] PAD_MASK = 32'h3FFF_FFFF & ~((32'h1 << NS) - 32'h1);

  logic need;
  assign need = intr_ctl[31] &
                ((int_sts[30] & intr_ctl[30]) | (|(int_sts[NS-1:0] & intr_ctl[NS-1:0])));

  a_r4_summary: assert property (@(posedge clk) disable iff (!rst_n)
    int_sts[31] == (|int_sts[30:0]));

  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sts & PAD_MASK) == 32'h0);

  a_r5_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_line == $past(need));

  a_r6_no_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_ctl[31] |=> !irq_line);

  a_r7_reset_low: assert property (@(posedge clk)
    !rst_n |=> !irq_line);

  a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
    line_up |=> irq_line);

  a_r8_fall: assert property (@(posedge clk) disable iff (!rst_n)
    line_dn |=> !irq_line);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_up && !line_dn) |=> $stable(irq_line));
endmodule

bind hda_irq_agg hda_irq_agg_chk #(.NS(NUM_IN + NUM_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .int_sts (int_sts),
  .intr_ctl(intr_ctl),
  .irq_line(irq_line),
  .line_up (line_up),
  .line_dn (line_dn)
);

// File: tb/hda_irq_agg_bench.sv
`timescale 1ns/1ps
module hda_irq_agg_bench;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam int NS = NI + NO;
  localparam int CW = 15;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      ring_sts = '0, ring_ctl = '0;
  logic [CW-1:0]   codec_chg = '0, wake_en = '0;
  logic [NS*8-1:0] sd_sts = '0, sd_ctl = '0;
  logic [31:0]     intr_ctl = '0;
  logic [31:0]     int_sts;
  logic            irq_line;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  hda_irq_agg #(.NUM_IN(NI), .NUM_OUT(NO), .CODEC_W(CW)) u_hda_irq_agg (
    .clk(clk), .rst_n(rst_n), .ring_sts(ring_sts), .ring_ctl(ring_ctl),
    .codec_chg(codec_chg), .wake_en(wake_en), .sd_sts(sd_sts), .sd_ctl(sd_ctl),
    .intr_ctl(intr_ctl), .int_sts(int_sts), .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [NS-1:0] s, input logic c);
    logic [31:0] w;
    w = {((s != 0) || c) ? 1'b1 : 1'b0, c, 30'h0};
    w[NS-1:0] = s;
    return w;
  endfunction

  initial begin
    #1900000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic exp_line;
    logic [NS-1:0] sv;
    // R7: reset holds the line low even with a qualified source
    ring_sts = 8'h01; ring_ctl = 8'h01; intr_ctl = 32'hC000_0000;
    repeat (3) @(negedge clk);
    chk("R7", {31'h0, irq_line}, 32'h0);
    chk("R1", int_sts, word_of('0, 1'b1));
    ring_sts = '0; ring_ctl = '0; intr_ctl = '0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R7", {31'h0, irq_line}, 32'h0);
    chk("R4", int_sts, 32'h0);

    // R3: full status x control sweep on stream 1
    for (int s = 0; s < 256; s++) begin
      for (int c = 0; c < 256; c++) begin
        sd_sts[8 +: 8] = 8'(s); sd_ctl[8 +: 8] = 8'(c);
        #1;
        sv = '0; sv[1] = |(8'(s) & 8'(c) & 8'h1C);
        chk("R3", int_sts, word_of(sv, 1'b0));
      end
    end
    sd_sts = '0; sd_ctl = '0;
    // R3: each stream index lands on its own bit, for every source bit
    for (int k = 0; k < NS; k++) begin
      for (int b = 0; b < 8; b++) begin
        sd_sts = '0; sd_ctl = '0;
        sd_sts[k*8 + b] = 1'b1; sd_ctl[k*8 + b] = 1'b1;
        #1;
        sv = '0; sv[k] = (b >= 2 && b <= 4);
        chk("R3", int_sts, word_of(sv, 1'b0));
      end
    end
    sd_sts = '0; sd_ctl = '0;

    // R1: full ring status x control sweep
    for (int s = 0; s < 256; s++) begin
      for (int c = 0; c < 256; c++) begin
        ring_sts = 8'(s); ring_ctl = 8'(c);
        #1;
        chk("R1", int_sts, word_of('0, |(8'(s) & 8'(c) & 8'h05)));
      end
    end
    ring_sts = '0; ring_ctl = '0;

    // R2: codec flags with every wake mask
    for (int f = 0; f < 16; f++) begin
      for (int w = 0; w < 16; w++) begin
        codec_chg = '0; wake_en = '0;
        codec_chg[2:0] = 3'(f); codec_chg[CW-1] = f[3];
        wake_en[2:0] = 3'(w); wake_en[CW-1] = w[3];
        #1;
        chk("R2", int_sts, word_of('0, f != 0));
      end
    end
    codec_chg = '0; wake_en = '0;

    // R5 R6 R8: line sweep across sources and enables
    for (int p = 0; p < 16; p++) begin
      for (int cs = 0; cs < 2; cs++) begin
        for (int e = 0; e < 64; e++) begin
          logic prev;
          @(negedge clk);
          prev = irq_line;
          for (int k = 0; k < NS; k++) begin
            sd_sts[k*8 +: 8] = p[k] ? 8'h04 : 8'h00;
            sd_ctl[k*8 +: 8] = 8'h1C;
          end
          ring_sts = cs[0] ? 8'h04 : 8'h00; ring_ctl = 8'h04;
          intr_ctl = {e[5], e[4], 26'h0, 4'(e)};
          #1;
          chk("R8", {31'h0, irq_line}, {31'h0, prev});
          exp_line = e[5] & ((cs[0] & e[4]) | (|(4'(p) & 4'(e))));
          @(negedge clk);
          chk("R5", {31'h0, irq_line}, {31'h0, exp_line});
          chk("R4", int_sts, word_of(4'(p), cs[0]));
          if (!exp_line && (p != 0 || cs != 0))
            chk("R6", {31'h0, irq_line}, 32'h0);
        end
      end
    end

    // R7: reset in the middle of an active line
    @(negedge clk);
    ring_sts = 8'h01; ring_ctl = 8'h01; intr_ctl = 32'hC000_0000;
    @(negedge clk);
    chk("R5", {31'h0, irq_line}, 32'h1);
    rst_n = 1'b0; #1;
    chk("R7", {31'h0, irq_line}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", {31'h0, irq_line}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule